// File: doc/BRIEF.md
# Serial Gain Control Front End

This block is the digital control side of a programmable-gain line driver. A host loads an 8-bit gain word over three wires: an active-low frame enable, a serial clock and a serial data line. The block samples these lines in its own system clock domain. It shifts the word into a holding register one bit per serial clock falling edge. When the enable line returns high, it moves a complete word into the gain latch.

The latched code drives two outputs. One is the raw code. The other is the linear gain (0.077 per step plus 0.316) as an unsigned fixed-point value with 10 fractional bits, which the analog side or a monitoring path can use. A separate active-low power-down input blanks the output-enable flag at once and without a clock. The latched gain is kept through power-down, so the driver resumes at the programmed level.

Top module: `sgc_frontend`

## Requirements
- R1: While reset is applied and in the first cycle after it, the gain code is 0, the linear gain output is 324 (0.316 in 10-bit fraction), and the output-enable flag follows the power-down input.
- R2: A frame opens when the enable input falls from high to low. Each serial clock falling edge inside the frame shifts in one data bit, most significant bit first. A frame holding exactly 8 such edges loads the 8-bit word into the gain latch when the enable input rises.
- R3: Serial data is sampled only on serial clock falling edges. The value on the data line at the rising edge has no effect on the loaded word.
- R4: The gain code never changes while a frame is open. After the enable input rises, the new code appears no earlier than the 2nd and no later than the 4th system clock cycle.
- R5: A frame that closes after 7 or 9 serial clock falling edges is discarded, and the gain code keeps its previous value.
- R6: Serial clock edges that arrive while the enable input is high are ignored, and the gain code is unchanged.
- R7: For every code c from 0 to 255, the linear gain output equals round((77*c + 316) * 1024 / 1000). This is 324 at code 0 and 20430 at code 255, and the value rises strictly with the code.
- R8: While the power-down input is low, the output-enable flag is low at once, with no system clock edge needed.
- R9: The gain code held before power-down is unchanged while power-down is applied and after it is released. The output-enable flag returns high once the power-down input is high again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_en_n | input | 1 | Frame enable, active low, asynchronous to clk |
| ser_clk | input | 1 | Serial clock, data taken on its falling edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| pwr_dn_n | input | 1 | Power-down, active low, asynchronous |
| gain_code | output | 8 | Latched gain code |
| gain_lin | output | 15 | Linear gain, unsigned, 10 fractional bits |
| out_en | output | 1 | Output-enable flag, low during power-down |

## Verification
The assertions assume that each serial line is held for several system clock periods between its changes. Under that assumption the synchronizers never hide an edge, and the data line has settled when the serial clock falls. They also assume that the enable line never rises in the same cycle as a serial clock falling edge. The stimulus keeps each serial clock phase at least three system cycles long. It changes data only while the serial clock is high, and it waits several cycles after the last falling edge before raising the enable line.

// File: rtl/sgc_pkg.sv
`timescale 1ns/1ps
package sgc_pkg;

   typedef enum logic {
      RX_IDLE   = 1'b0,
      RX_ACTIVE = 1'b1
   } rx_state_e;

   // Linear gain in fixed point, rounded to nearest:
   // ((slope*code + offset) / 1000) scaled by 2^frac_w.
   function automatic logic [63:0] lin_gain_q(
      input logic [63:0] code,
      input int          slope_milli,
      input int          offset_milli,
      input int          frac_w
   );
      logic [63:0] num;
      num = (code * 64'(slope_milli) + 64'(offset_milli)) << frac_w;
      return (num + 64'd500) / 64'd1000;
   endfunction

endpackage

// File: rtl/sgc_sync.sv
`timescale 1ns/1ps
module sgc_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sgc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_w
      $error("sgc_sync: W must be at least 1");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stage_q[0] <= RST_VAL;
            else     stage_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sgc_rx.sv
`timescale 1ns/1ps
module sgc_rx #(
   parameter int CODE_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_n_s,
   input  logic              sclk_s,
   input  logic              sdat_s,
   output logic [CODE_W-1:0] code_q,
   output logic              active,
   output logic [CNT_W-1:0]  bits_q,
   output logic [CODE_W-1:0] shreg_q
);
   import sgc_pkg::*;

   localparam logic [CNT_W-1:0] FULL  = CNT_W'(CODE_W);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CODE_W + 1);

   if ((1 << CNT_W) <= CODE_W + 1) begin : g_bad_cnt
      $error("sgc_rx: CNT_W too narrow for CODE_W + 1");
   end
   if (CODE_W < 2) begin : g_bad_code
      $error("sgc_rx: CODE_W must be at least 2");
   end

   rx_state_e st_q;
   logic      en_prev_q;
   logic      sclk_prev_q;
   logic      en_fall;
   logic      en_rise;
   logic      sclk_fall;

   always_comb begin
      en_fall   = en_prev_q & ~en_n_s;
      en_rise   = ~en_prev_q & en_n_s;
      sclk_fall = sclk_prev_q & ~sclk_s;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         en_prev_q   <= 1'b1;
         sclk_prev_q <= 1'b0;
         st_q        <= RX_IDLE;
         bits_q      <= '0;
         shreg_q     <= '0;
         code_q      <= '0;
      end else begin
         en_prev_q   <= en_n_s;
         sclk_prev_q <= sclk_s;
         case (st_q)
            RX_IDLE: begin
               if (en_fall) begin
                  st_q   <= RX_ACTIVE;
                  bits_q <= '0;
               end
            end
            RX_ACTIVE: begin
               if (sclk_fall) begin
                  shreg_q <= {shreg_q[CODE_W-2:0], sdat_s};
                  if (bits_q != LIMIT) bits_q <= bits_q + 1'b1;
               end
               if (en_rise) begin
                  st_q <= RX_IDLE;
                  if (bits_q == FULL) code_q <= shreg_q;
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign active = (st_q == RX_ACTIVE);

endmodule

// File: rtl/sgc_gain_map.sv
`timescale 1ns/1ps
module sgc_gain_map #(
   parameter int CODE_W       = 8,
   parameter int FRAC_W       = 10,
   parameter int GAIN_W       = 15,
   parameter int SLOPE_MILLI  = 77,
   parameter int OFFSET_MILLI = 316,
   parameter bit USE_TABLE    = 1'b1
) (
   input  logic [CODE_W-1:0] code,
   output logic [GAIN_W-1:0] gain_q
);

   if (USE_TABLE) begin : g_table
      localparam int N = 1 << CODE_W;
      if (CODE_W > 10) begin : g_bad_table
         $error("sgc_gain_map: table variant limited to CODE_W <= 10");
      end
      logic [GAIN_W-1:0] tbl [N];
      for (genvar k = 0; k < N; k++) begin : g_ent
         assign tbl[k] = GAIN_W'(sgc_pkg::lin_gain_q(64'(k), SLOPE_MILLI,
                                                     OFFSET_MILLI, FRAC_W));
      end
      assign gain_q = tbl[code];
   end else begin : g_arith
      always_comb begin
         gain_q = GAIN_W'(sgc_pkg::lin_gain_q(64'(code), SLOPE_MILLI,
                                              OFFSET_MILLI, FRAC_W));
      end
   end

endmodule

// File: rtl/sgc_frontend.sv
`timescale 1ns/1ps
module sgc_frontend #(
   parameter int CODE_W        = 8,
   parameter int FRAC_W        = 10,
   parameter int GAIN_W        = 15,
   parameter int SYNC_STAGES   = 2,
   parameter int SLOPE_MILLI   = 77,
   parameter int OFFSET_MILLI  = 316,
   parameter bit USE_TABLE     = 1'b1,
   parameter bit PD_REARM_SYNC = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ser_en_n,
   input  logic              ser_clk,
   input  logic              ser_dat,
   input  logic              pwr_dn_n,
   output logic [CODE_W-1:0] gain_code,
   output logic [GAIN_W-1:0] gain_lin,
   output logic              out_en
);

   localparam int          CNT_W = $clog2(CODE_W + 2);
   localparam logic [63:0] MAX_Q = sgc_pkg::lin_gain_q((64'd1 << CODE_W) - 64'd1,
                                       SLOPE_MILLI, OFFSET_MILLI, FRAC_W);

   if (MAX_Q >= (64'd1 << GAIN_W)) begin : g_bad_gain_w
      $error("sgc_frontend: GAIN_W cannot hold the largest gain value");
   end
   if (FRAC_W < 0 || FRAC_W > 24) begin : g_bad_frac
      $error("sgc_frontend: FRAC_W out of range");
   end

   logic [2:0]        ser_s;
   logic              rx_active;
   logic [CNT_W-1:0]  rx_bits;
   logic [CODE_W-1:0] rx_shreg;

   sgc_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_ser_sync (
      .clk (clk),
      .rst (rst),
      .d   ({ser_en_n, ser_clk, ser_dat}),
      .q   (ser_s)
   );

   sgc_rx #(
      .CODE_W (CODE_W),
      .CNT_W  (CNT_W)
   ) u_rx (
      .clk     (clk),
      .rst     (rst),
      .en_n_s  (ser_s[2]),
      .sclk_s  (ser_s[1]),
      .sdat_s  (ser_s[0]),
      .code_q  (gain_code),
      .active  (rx_active),
      .bits_q  (rx_bits),
      .shreg_q (rx_shreg)
   );

   sgc_gain_map #(
      .CODE_W       (CODE_W),
      .FRAC_W       (FRAC_W),
      .GAIN_W       (GAIN_W),
      .SLOPE_MILLI  (SLOPE_MILLI),
      .OFFSET_MILLI (OFFSET_MILLI),
      .USE_TABLE    (USE_TABLE)
   ) u_map (
      .code   (gain_code),
      .gain_q (gain_lin)
   );

   // Blanking is always immediate; the variant only changes re-enable.
   if (PD_REARM_SYNC) begin : g_pd_sync
      logic pd_s;
      sgc_sync #(
         .W       (1),
         .STAGES  (SYNC_STAGES),
         .RST_VAL (1'b1)
      ) u_pd_sync (
         .clk (clk),
         .rst (rst),
         .d   (pwr_dn_n),
         .q   (pd_s)
      );
      assign out_en = pwr_dn_n & pd_s;
   end else begin : g_pd_async
      assign out_en = pwr_dn_n;
   end

endmodule

// File: rtl/sgc_frontend_chk.sv
`timescale 1ns/1ps
module sgc_frontend_chk #(
   parameter int CODE_W = 8,
   parameter int GAIN_W = 15,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              pwr_dn_n,
   input logic              out_en,
   input logic [CODE_W-1:0] gain_code,
   input logic [GAIN_W-1:0] gain_lin,
   input logic              rx_active,
   input logic [CNT_W-1:0]  rx_bits,
   input logic [CODE_W-1:0] rx_shreg
);

   // R1: code comes out of reset at zero
   a_r1_reset_code: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (gain_code == '0));

   // R4: code moves only right after a full frame closes
   a_r4_commit_after_frame: assert property (@(posedge clk) disable iff (rst)
      (gain_code != $past(gain_code)) |->
         ($past(rx_active) && ($past(rx_bits) == CNT_W'(CODE_W))));

   // R5: the bit count saturates one past a full word
   a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
      rx_bits <= CNT_W'(CODE_W + 1));

   // R6: no shifting outside a frame
   a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
      (!rx_active && !$past(rx_active)) |-> $stable(rx_shreg));

   // R7: linear gain rises with the code
   a_r7_monotonic: assert property (@(posedge clk) disable iff (rst)
      (gain_code > $past(gain_code)) |-> (gain_lin > $past(gain_lin)));

   // R8: power-down blanks the output
   a_r8_pd_blank: assert property (@(posedge clk) disable iff (rst)
      !pwr_dn_n |-> !out_en);

endmodule

bind sgc_frontend sgc_frontend_chk #(
   .CODE_W (CODE_W),
   .GAIN_W (GAIN_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .pwr_dn_n  (pwr_dn_n),
   .out_en    (out_en),
   .gain_code (gain_code),
   .gain_lin  (gain_lin),
   .rx_active (rx_active),
   .rx_bits   (rx_bits),
   .rx_shreg  (rx_shreg)
);

// File: tb/sgc_frontend_tb_top.sv
`timescale 1ns/1ps
module sgc_frontend_tb_top;

   logic        clk = 1'b0;
   logic        rst;
   logic        ser_en_n;
   logic        ser_clk;
   logic        ser_dat;
   logic        pwr_dn_n;
   logic [7:0]  gain_code;
   logic [14:0] gain_lin;
   logic        out_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   sgc_frontend dut_i (
      .clk       (clk),
      .rst       (rst),
      .ser_en_n  (ser_en_n),
      .ser_clk   (ser_clk),
      .ser_dat   (ser_dat),
      .pwr_dn_n  (pwr_dn_n),
      .gain_code (gain_code),
      .gain_lin  (gain_lin),
      .out_en    (out_en)
   );

   function automatic int exp_q(int c);
      return ((77 * c + 316) * 1024 + 500) / 1000;
   endfunction

   task automatic chk(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   // Open a frame and shift nb bits, MSB first; data holds the wrong
   // value at the rising edge and the right one before the falling edge.
   task automatic frame_bits(logic [15:0] w, int nb);
      ser_en_n = 1'b0;
      cyc(4);
      for (int i = nb - 1; i >= 0; i--) begin
         ser_clk = 1'b1;
         ser_dat = ~w[i];
         cyc(3);
         ser_dat = w[i];
         cyc(3);
         ser_clk = 1'b0;
         cyc(4);
      end
      cyc(2);
   endtask

   task automatic close_frame();
      ser_en_n = 1'b1;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         summary();
         $finish;
      end
   end

   initial begin
      int prev;
      rst      = 1'b1;
      ser_en_n = 1'b1;
      ser_clk  = 1'b0;
      ser_dat  = 1'b0;
      pwr_dn_n = 1'b1;
      cyc(5);
      rst = 1'b0;
      cyc(1);
      // R1
      chk(gain_code == 8'd0, "R1 reset code", int'(gain_code), 0);
      chk(gain_lin == 15'd324, "R1 reset gain", int'(gain_lin), 324);
      chk(out_en == 1'b1, "R1 reset out_en", int'(out_en), 1);

      // R2 R3 R4 R7: sweep all codes in a scrambled order
      prev = 0;
      for (int k = 0; k < 256; k++) begin
         int c;
         c = (k * 167 + 5) % 256;
         frame_bits(16'(c), 8);
         chk(gain_code == 8'(prev), "R4 no change in open frame", int'(gain_code), prev);
         close_frame();
         cyc(1);
         chk(gain_code == 8'(prev), "R4 not before 2nd cycle", int'(gain_code), prev);
         cyc(3);
         chk(gain_code == 8'(c), "R2 R3 loaded word", int'(gain_code), c);
         chk(gain_lin == 15'(exp_q(c)), "R7 linear gain", int'(gain_lin), exp_q(c));
         prev = c;
      end

      // R7 end points
      frame_bits(16'h00, 8); close_frame(); cyc(6);
      chk(gain_lin == 15'd324, "R7 gain at code 0", int'(gain_lin), 324);
      frame_bits(16'hFF, 8); close_frame(); cyc(6);
      chk(gain_lin == 15'd20430, "R7 gain at code 255", int'(gain_lin), 20430);

      // R5: short and long frames discarded
      frame_bits(16'h3C, 7); close_frame(); cyc(8);
      chk(gain_code == 8'hFF, "R5 seven-bit frame", int'(gain_code), 255);
      frame_bits(16'h1A5, 9); close_frame(); cyc(8);
      chk(gain_code == 8'hFF, "R5 nine-bit frame", int'(gain_code), 255);
      frame_bits(16'h5A, 8); close_frame(); cyc(8);
      chk(gain_code == 8'h5A, "R5 full frame after bad ones", int'(gain_code), 90);

      // R6: clock activity with enable high
      for (int i = 0; i < 10; i++) begin
         ser_dat = i[0];
         ser_clk = 1'b1; cyc(4);
         ser_clk = 1'b0; cyc(4);
      end
      cyc(6);
      chk(gain_code == 8'h5A, "R6 idle clocks ignored", int'(gain_code), 90);
      frame_bits(16'h81, 8); close_frame(); cyc(8);
      chk(gain_code == 8'h81, "R6 next frame intact", int'(gain_code), 129);

      // R8: immediate blanking
      pwr_dn_n = 1'b0;
      #1;
      chk(out_en == 1'b0, "R8 blank without clock", int'(out_en), 0);
      cyc(20);
      chk(out_en == 1'b0, "R8 stays blanked", int'(out_en), 0);
      // R9: code held through power-down
      chk(gain_code == 8'h81, "R9 code during power-down", int'(gain_code), 129);
      chk(gain_lin == 15'(exp_q(129)), "R9 gain during power-down", int'(gain_lin), exp_q(129));
      pwr_dn_n = 1'b1;
      cyc(4);
      chk(out_en == 1'b1, "R9 re-enabled", int'(out_en), 1);
      chk(gain_code == 8'h81, "R9 code after power-down", int'(gain_code), 129);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule